// File: doc/BRIEF.md
# Per-Bit Eye Center Finder

This block calibrates the receive timing of a wide memory data bus one bit line at a time. For each lane it steps a delay tap code across a programmed range. It holds each code long enough for the analog path to settle, then samples a pass/fail verdict from an external compare datapath. From those verdicts it keeps the longest unbroken run of passing codes and stores that run's midpoint as the trained delay for the lane. Equal setup and hold margin follows from centering.

A sweep covers 64 data lanes, or 72 when the error-correction lanes are enabled. While a sweep runs the block also drives a single-bit stress pattern for the pattern generator. The pattern is an alternating toggle or one of two pseudo-random sequences. A second mode runs the same centering search once on a vertical reference-level code, with one threshold step per code, and keeps the result separately. Software starts a sweep with a start pulse, waits for done, and then reads the stored per-lane delays and fail bits through a combinational readback port.

Top module: `eye_center_trainer`

## Requirements
- R1: When `start` is high in an idle cycle, `busy` rises in the next cycle. When the last lane finishes, `done` is high for exactly one cycle with `busy` low, and the block is then idle. `start` has no effect while `busy` is high.
- R2: The sweep applies codes from `code_lo` upward in steps of one and stops after `code_hi`. If `code_lo` > `code_hi`, only `code_lo` is tested. Each code is held on `sweep_code` for `settle`+1 cycles, and `cmp_pass` is sampled in the last of those cycles. All configuration is latched at start.
- R3: Lanes are swept in ascending order on `sweep_lane`: 0..63 when `ecc_en` is 0 at start, and 0..71 when it is 1. After the last code of a lane there is one extra busy cycle before the next lane begins.
- R4: The passing window of a lane is the longest run of consecutive passing codes. When two runs have equal length, the one at lower codes wins. Passing codes outside that run do not affect the result.
- R5: The stored result is window start + (window length − 1)/2, rounded down. An even-length window therefore gives the lower of its two middle codes.
- R6: A lane with no passing code gets its fail bit set and keeps its previously stored delay. A lane that passes gets its fail bit cleared. `any_fail` is cleared at start and is set if any sweep in the run failed.
- R7: `rd_delay` and `rd_fail` show the stored delay and fail bit of lane `rd_lane` combinationally. After reset every stored delay is `DLY_INIT` (default 32), every fail bit is 0, `vref_level` is `VREF_INIT` (default 32) and `vref_fail` is 0.
- R8: `pat_bit` is bit 0 of a 31-bit generator state, which is set to all ones by the start edge. At every edge while `busy` is high, the state shifts left by one and takes a new bit 0 equal to: the inverse of bit 0 when `pat_sel`=0 (toggle); bit22 XOR bit17 when `pat_sel`=1 (PRBS23); bit30 XOR bit27 when `pat_sel` is 2 or 3 (PRBS31).
- R9: With `vref_mode` set at start, one sweep runs with `sweep_lane` at 0 and `sweep_vref` high. Its centered result goes to `vref_level` and its failure to `vref_fail`. On failure `vref_level` is unchanged, and the per-lane delays are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep when idle |
| ecc_en | input | 1 | Include the 8 error-correction lanes |
| vref_mode | input | 1 | Sweep the reference level instead of lane delays |
| pat_sel | input | 2 | Stress pattern: 0 toggle, 1 PRBS23, 2/3 PRBS31 |
| code_lo | input | CODE_W | First code of the sweep |
| code_hi | input | CODE_W | Last code of the sweep |
| settle | input | SETTLE_W | Extra cycles each code is held before sampling |
| cmp_pass | input | 1 | Compare verdict for the current code |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| any_fail | output | 1 | Some sweep of the last run had no passing code |
| sweep_vref | output | 1 | Current code is a reference level |
| sweep_lane | output | LANE_W | Lane under calibration |
| sweep_code | output | CODE_W | Tap or reference code being applied |
| pat_bit | output | 1 | Stress pattern bit |
| rd_lane | input | LANE_W | Readback lane index |
| rd_delay | output | CODE_W | Stored delay of `rd_lane` |
| rd_fail | output | 1 | Fail bit of `rd_lane` |
| vref_level | output | CODE_W | Trained reference-level code |
| vref_fail | output | 1 | Reference sweep found no passing level |

## Verification
The bench builds the block with its default parameters: 64 data lanes plus 8 error-correction lanes, and 6-bit codes. Sweep ranges of 9 to 21 codes and settle counts of 0 to 2 keep a full 72-lane run within a few thousand cycles. With these sizes the bench can exercise both lane counts, windows of every parity, tied runs, stray passing codes, a reversed range, and a lane that fails after having passed. A behavioural model predicts lane, code, pattern and handshake on every cycle, and it predicts the centered results for all three pattern modes and both sweep kinds.

// File: rtl/eye_center_trainer.sv
module eye_center_trainer #(
  parameter int DATA_LANES = 64,
  parameter int ECC_LANES  = 8,
  parameter int CODE_W     = 6,
  parameter int SETTLE_W   = 8,
  parameter int DLY_INIT   = 32,
  parameter int VREF_INIT  = 32,
  localparam int LANES     = DATA_LANES + ECC_LANES,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ecc_en,
  input  logic                vref_mode,
  input  logic [1:0]          pat_sel,
  input  logic [CODE_W-1:0]   code_lo,
  input  logic [CODE_W-1:0]   code_hi,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                cmp_pass,
  output logic                busy,
  output logic                done,
  output logic                any_fail,
  output logic                sweep_vref,
  output logic [LANE_W-1:0]   sweep_lane,
  output logic [CODE_W-1:0]   sweep_code,
  output logic                pat_bit,
  input  logic [LANE_W-1:0]   rd_lane,
  output logic [CODE_W-1:0]   rd_delay,
  output logic                rd_fail,
  output logic [CODE_W-1:0]   vref_level,
  output logic                vref_fail
);
  localparam int LEN_W = CODE_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_END, S_DONE} st_t;

  st_t                st;
  logic [LANE_W-1:0]  lane;
  logic [CODE_W-1:0]  code, lo_q, hi_q;
  logic [SETTLE_W-1:0] cnt, settle_q;
  logic               ecc_q, vref_q;
  logic [1:0]         pat_q;
  logic [CODE_W-1:0]  run_start, best_start;
  logic [LEN_W-1:0]   run_len, best_len;
  logic [30:0]        lfsr;
  logic [CODE_W-1:0]  dly_mem [LANES];
  logic [LANES-1:0]   fail_mem;
  logic [CODE_W-1:0]  vref_r;
  logic               vref_f, fail_any;

  logic               last_code, last_lane, fb, no_win;
  logic [CODE_W-1:0]  ext_start, center;
  logic [LEN_W-1:0]   ext_len, half;

  assign last_code = code >= hi_q;
  assign last_lane = vref_q || (lane == LANE_W'(ecc_q ? LANES - 1 : DATA_LANES - 1));
  assign ext_start = (run_len == '0) ? code : run_start;
  assign ext_len   = run_len + LEN_W'(1);
  assign half      = (best_len - LEN_W'(1)) >> 1;
  assign center    = best_start + half[CODE_W-1:0];
  assign no_win    = best_len == '0;

  always_comb begin
    case (pat_q)
      2'd0:    fb = ~lfsr[0];
      2'd1:    fb = lfsr[22] ^ lfsr[17];
      default: fb = lfsr[30] ^ lfsr[27];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lane       <= '0;
      code       <= '0;
      cnt        <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      settle_q   <= '0;
      ecc_q      <= 1'b0;
      vref_q     <= 1'b0;
      pat_q      <= '0;
      run_start  <= '0;
      run_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
      lfsr       <= '1;
      fail_mem   <= '0;
      vref_r     <= CODE_W'(VREF_INIT);
      vref_f     <= 1'b0;
      fail_any   <= 1'b0;
      for (int i = 0; i < LANES; i++) dly_mem[i] <= CODE_W'(DLY_INIT);
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st         <= S_SETTLE;
          lo_q       <= code_lo;
          hi_q       <= code_hi;
          settle_q   <= settle;
          ecc_q      <= ecc_en;
          vref_q     <= vref_mode;
          pat_q      <= pat_sel;
          lane       <= '0;
          code       <= code_lo;
          cnt        <= settle;
          run_len    <= '0;
          best_len   <= '0;
          best_start <= '0;
          fail_any   <= 1'b0;
          lfsr       <= '1;
        end
        S_SETTLE: begin
          lfsr <= {lfsr[29:0], fb};
          if (cnt != '0) begin
            cnt <= cnt - SETTLE_W'(1);
          end else begin
            if (cmp_pass) begin
              run_start <= ext_start;
              run_len   <= ext_len;
              if (ext_len > best_len) begin
                best_start <= ext_start;
                best_len   <= ext_len;
              end
            end else begin
              run_len <= '0;
            end
            if (last_code) begin
              st <= S_END;
            end else begin
              code <= code + CODE_W'(1);
              cnt  <= settle_q;
            end
          end
        end
        S_END: begin
          lfsr <= {lfsr[29:0], fb};
          if (no_win) fail_any <= 1'b1;
          if (vref_q) begin
            vref_f <= no_win;
            if (!no_win) vref_r <= center;
          end else begin
            fail_mem[lane] <= no_win;
            if (!no_win) dly_mem[lane] <= center;
          end
          if (last_lane) begin
            st <= S_DONE;
          end else begin
            st       <= S_SETTLE;
            lane     <= lane + LANE_W'(1);
            code     <= lo_q;
            cnt      <= settle_q;
            run_len  <= '0;
            best_len <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st == S_SETTLE) || (st == S_END);
  assign done       = st == S_DONE;
  assign any_fail   = fail_any;
  assign sweep_vref = vref_q;
  assign sweep_lane = lane;
  assign sweep_code = code;
  assign pat_bit    = lfsr[0];
  assign rd_delay   = (rd_lane < LANE_W'(LANES)) ? dly_mem[rd_lane] : '0;
  assign rd_fail    = (rd_lane < LANE_W'(LANES)) ? fail_mem[rd_lane] : 1'b0;
  assign vref_level = vref_r;
  assign vref_fail  = vref_f;

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && cnt != '0) |=> ($stable(sweep_code) && $stable(sweep_lane)));
  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sweep_code >= lo_q && (sweep_code <= hi_q || sweep_code == lo_q)));
  // R3
  lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sweep_lane < LANE_W'(ecc_q ? LANES : DATA_LANES)));
  // R6
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END && no_win && !vref_q) |=>
      (dly_mem[$past(lane)] == $past(dly_mem[lane]) && fail_mem[$past(lane)]));
  // R8
  toggle_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && pat_q == 2'd0) |-> (pat_bit != $past(pat_bit)));
endmodule

// File: tb/eye_center_trainer_tb.sv
`timescale 1ns/1ps
module eye_center_trainer_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, ecc_en = 0, vref_mode = 0;
  logic [1:0] pat_sel = 0;
  logic [5:0] code_lo = 0, code_hi = 0;
  logic [7:0] settle = 0;
  logic cmp_pass;
  logic busy, done, any_fail, sweep_vref, pat_bit, rd_fail, vref_fail;
  logic [6:0] sweep_lane, rd_lane = 0;
  logic [5:0] sweep_code, rd_delay, vref_level;

  int scen = 0, checks = 0, fails = 0;
  bit finished = 0;
  int exp_dly [72];
  bit exp_fail [72];
  int exp_vref = 32;
  bit exp_vfail = 0;

  always #2.5 clk = ~clk;

  eye_center_trainer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ecc_en(ecc_en), .vref_mode(vref_mode),
    .pat_sel(pat_sel), .code_lo(code_lo), .code_hi(code_hi), .settle(settle),
    .cmp_pass(cmp_pass), .busy(busy), .done(done), .any_fail(any_fail),
    .sweep_vref(sweep_vref), .sweep_lane(sweep_lane), .sweep_code(sweep_code),
    .pat_bit(pat_bit), .rd_lane(rd_lane), .rd_delay(rd_delay), .rd_fail(rd_fail),
    .vref_level(vref_level), .vref_fail(vref_fail));

  function automatic bit pass_fn(int sc, int ln, int cd);
    int w;
    case (sc)
      0: begin
        if (ln == 10) return 0;
        if (ln % 3 == 0 && cd == 15) return 1;
        return cd >= ln % 5 + 2 && cd <= ln % 5 + 2 + ln % 7;
      end
      1: begin
        if (ln == 20) return 0;
        w = ln % 3 + 1;
        if (cd >= 4 && cd < 4 + w) return 1;
        return cd >= 9 && cd < 9 + w + ((ln % 4 == 0) ? 1 : 0);
      end
      2: return cd >= 7 && cd <= 12;
      4: return cd == 9;
      default: return 0;
    endcase
  endfunction

  assign cmp_pass = pass_fn(scen, int'(sweep_lane), int'(sweep_code));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] pat_next(logic [30:0] m, int ps);
    logic f;
    if (ps == 0) f = ~m[0];
    else if (ps == 1) f = m[22] ^ m[17];
    else f = m[30] ^ m[27];
    return {m[29:0], f};
  endfunction

  // Longest run, earliest on ties; centre rounded down (R4, R5)
  task automatic expect_lane(int sc, int ln, int lo, int hi, output bit ok, output int ctr);
    int cd, rs, rl, bs, bl;
    cd = lo; rl = 0; bs = 0; bl = 0; rs = 0;
    while (1) begin
      if (pass_fn(sc, ln, cd)) begin
        if (rl == 0) rs = cd;
        rl++;
        if (rl > bl) begin bl = rl; bs = rs; end
      end else rl = 0;
      if (cd >= hi) break;
      cd++;
    end
    ok = bl > 0;
    ctr = bs + (bl - 1) / 2;
  endtask

  task automatic run_sweep(int sc, bit ecc, bit vm, int ps, int lo, int hi, int s, int poke);
    logic [30:0] m;
    int nl, nc, cyc;
    bit ok, anyf;
    int c;
    @(negedge clk);
    scen = sc; ecc_en = ecc; vref_mode = vm; pat_sel = 2'(ps);
    code_lo = 6'(lo); code_hi = 6'(hi); settle = 8'(s); start = 1;
    @(negedge clk);
    start = 0;
    code_lo = 6'(hi); code_hi = 6'(lo); settle = 8'(s + 3); ecc_en = ~ecc; vref_mode = ~vm;
    m = '1;
    nl = vm ? 1 : (ecc ? 72 : 64);
    nc = (hi >= lo) ? hi - lo + 1 : 1;
    cyc = 0;
    for (int l = 0; l < nl; l++) begin
      for (int k = 0; k < nc; k++) begin
        for (int t = 0; t <= s; t++) begin
          chk(busy === 1'b1 && done === 1'b0, "R1 busy", int'(busy), 1);
          chk(int'(sweep_lane) == l, "R3 lane", int'(sweep_lane), l);
          chk(int'(sweep_code) == lo + k, "R2 code", int'(sweep_code), lo + k);
          chk(sweep_vref === vm, "R9 vref flag", int'(sweep_vref), int'(vm));
          chk(pat_bit === m[0], "R8 pattern", int'(pat_bit), int'(m[0]));
          m = pat_next(m, ps);
          cyc++;
          start = (cyc == poke);
          @(negedge clk);
        end
      end
      chk(busy === 1'b1, "R3 end cycle busy", int'(busy), 1);
      chk(int'(sweep_code) == lo + nc - 1, "R3 end cycle code", int'(sweep_code), lo + nc - 1);
      chk(pat_bit === m[0], "R8 pattern", int'(pat_bit), int'(m[0]));
      m = pat_next(m, ps);
      start = 0;
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0, "R1 done pulse", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R1 idle after done", int'(done), 0);
    anyf = 0;
    for (int l = 0; l < nl; l++) begin
      expect_lane(sc, l, lo, hi, ok, c);
      if (!ok) anyf = 1;
      if (vm) begin
        exp_vfail = !ok;
        if (ok) exp_vref = c;
      end else begin
        exp_fail[l] = !ok;
        if (ok) exp_dly[l] = c;
      end
    end
    chk(any_fail === anyf, "R6 any_fail", int'(any_fail), int'(anyf));
    chk(int'(vref_level) == exp_vref, "R9 vref level", int'(vref_level), exp_vref);
    chk(vref_fail === exp_vfail, "R9 vref fail", int'(vref_fail), int'(exp_vfail));
    for (int l = 0; l < 72; l++) begin
      rd_lane = 7'(l);
      #0.5;
      chk(int'(rd_delay) == exp_dly[l], "R5 R7 stored delay", int'(rd_delay), exp_dly[l]);
      chk(rd_fail === exp_fail[l], "R6 fail bit", int'(rd_fail), int'(exp_fail[l]));
    end
  endtask

  initial begin
    for (int l = 0; l < 72; l++) begin exp_dly[l] = 32; exp_fail[l] = 0; end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R7 reset handshake", int'(busy), 0);
    chk(any_fail === 1'b0, "R7 reset any_fail", int'(any_fail), 0);
    chk(int'(vref_level) == 32 && vref_fail === 1'b0, "R7 reset vref", int'(vref_level), 32);
    rd_lane = 7'd5; #0.5;
    chk(int'(rd_delay) == 32 && rd_fail === 1'b0, "R7 reset delay", int'(rd_delay), 32);
    rst_n = 1;
    // R3 R4 R5 toggle, 64 lanes, stray passes, dead lane 10, restart poke ignored (R1)
    run_sweep(0, 0, 0, 0, 0, 15, 2, 60);
    // R3 R4 R6 PRBS23, 72 lanes, tied runs, lane 10 recovers, lane 20 dies
    run_sweep(1, 1, 0, 1, 4, 12, 0, 5);
    // R9 PRBS31 reference sweep, window 7..12
    run_sweep(2, 0, 1, 2, 0, 20, 1, 0);
    // R9 reference sweep with no pass keeps level
    run_sweep(3, 0, 1, 3, 2, 14, 0, 0);
    // R2 reversed range tests only code_lo
    run_sweep(4, 1, 0, 2, 9, 3, 1, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule